// File: doc/BRIEF.md
# PHY Delay Register Access Port

This block is an indirect write port into a bank of PHY input-delay settings. The bank is indexed by an 8-bit slot number. Software sees one 32-bit word at byte offset 0x10 of a small register bus. It loads a slot number and a delay value into that word with the request bit low. It then sets the request bit and polls until the acknowledge bit reads 1. Last, it clears the request and polls until the acknowledge reads 0. The bank is written once per handshake, at the moment the request is seen rising.

A handshake engine runs this exchange. It has four named states:
- `HS_IDLE`: acknowledge low. A request seen high commits the write and moves to `HS_SETTLE`.
- `HS_SETTLE`: acknowledge still low. Moves on unconditionally to `HS_HOLD`.
- `HS_HOLD`: acknowledge high. Stays while the request is high, and moves to `HS_CLEAR` once it is low.
- `HS_CLEAR`: acknowledge still high. Moves on unconditionally to `HS_IDLE`.

A two-bit speed-mode input picks which of four bank slots drives the delay output:

| mode_sel | Speed mode | Slot |
|---|---|---|
| 0 | default speed | 0x01 |
| 1 | high speed | 0x00 |
| 2 | SDR50 | 0x04 |
| 3 | DDR50 | 0x05 |

Every other slot can be written but never reaches the output.

Top module: `phy_dly_port`

## Requirements
- R1: After reset, the port word at offset 0x10 reads 0 and the acknowledge is low. The delay output gives 0x04 for mode_sel 0, 0x04 for 1, 0x06 for 2 and 0x16 for 3.
- R2: A bus write to offset 0x10 stores the slot number from bits [7:0], the value from bits [15:8] and the request from bit 24. Reading offset 0x10 returns those same fields plus the acknowledge in bit 25, with every other bit 0.
- R3: A bus write to any offset other than 0x10 changes nothing, and a read at such an offset returns 0.
- R4: When the request rises from `HS_IDLE`, the acknowledge reads 1 from the second clock edge after the edge that stored the request. Before that it reads 0.
- R5: When the request falls in `HS_HOLD`, the acknowledge stays 1 for one more edge and reads 0 from the second edge after the edge that cleared the request.
- R6: The bank write happens exactly once per rising request, one edge after the request is stored. It uses the slot number and value held at that moment. Rewriting the port word while the request stays high writes nothing.
- R7: The delay output shows the slot that mode_sel selects (0→0x01, 1→0x00, 2→0x04, 3→0x05), combinationally from mode_sel. It shows a newly committed value right after the commit edge.
- R8: Committing to a slot other than 0x00, 0x01, 0x04 or 0x05 leaves the delay output unchanged for every mode.
- R9: Bit 25 of a bus write is ignored: the acknowledge is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Register byte offset for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mode_sel | input | 2 | Speed-mode select for the delay output |
| delay_out | output | 8 | Delay value of the selected slot |

## Verification
The time origin is the clock edge that stores a request-high word. At that origin the bank write lands one edge later, and the acknowledge turns 1 two edges later. A request-low word lands at its own origin edge, and the acknowledge turns 0 two edges after that edge. The bench drives and samples on the falling clock edge, counting falling edges from the origin. It checks the acknowledge at zero, one and two edges after each request change, and checks the delay output for all four modes one edge after a rising request. Read data and delay output are combinational, so they are checked a fraction of a nanosecond after the address or mode changes, within the same low clock phase.

// File: rtl/phy_dly_pkg.sv
package phy_dly_pkg;

    parameter int BUS_W = 32;
    parameter int IDX_W = 8;
    parameter int VAL_W = 8;
    parameter int REQ_BIT = 24;
    parameter int ACK_BIT = 25;

    localparam int DATA_LSB = IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_SETTLE = 2'd1,
        HS_HOLD   = 2'd2,
        HS_CLEAR  = 2'd3
    } hs_state_e;

    typedef struct packed {
        logic             req;
        logic [VAL_W-1:0] val;
        logic [IDX_W-1:0] idx;
    } port_fields_t;

    localparam logic [IDX_W-1:0] SLOT_HIGH    = IDX_W'(8'h00);
    localparam logic [IDX_W-1:0] SLOT_DEFAULT = IDX_W'(8'h01);
    localparam logic [IDX_W-1:0] SLOT_SDR50   = IDX_W'(8'h04);
    localparam logic [IDX_W-1:0] SLOT_DDR50   = IDX_W'(8'h05);

    function automatic logic [IDX_W-1:0] mode_slot(input logic [1:0] mode);
        logic [IDX_W-1:0] s;
        unique case (mode)
            2'd0: s = SLOT_DEFAULT;
            2'd1: s = SLOT_HIGH;
            2'd2: s = SLOT_SDR50;
            default: s = SLOT_DDR50;
        endcase
        return s;
    endfunction

    function automatic logic [VAL_W-1:0] slot_reset_val(input logic [IDX_W-1:0] s);
        logic [VAL_W-1:0] v;
        if (s == SLOT_HIGH || s == SLOT_DEFAULT) v = VAL_W'(8'h04);
        else if (s == SLOT_SDR50)                v = VAL_W'(8'h06);
        else if (s == SLOT_DDR50)                v = VAL_W'(8'h16);
        else                                     v = '0;
        return v;
    endfunction

endpackage

// File: rtl/phy_dly_portreg.sv
module phy_dly_portreg
    import phy_dly_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] PORT_OFS = ADDR_W'(8'h10)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              ack,
    output port_fields_t      fields,
    output logic [BUS_W-1:0]  bus_rdata
);

    logic hit;
    logic unused_wbits;

    assign hit = (bus_addr == PORT_OFS);
    assign unused_wbits = ^{bus_wdata[BUS_W-1:REQ_BIT+1],
                            bus_wdata[REQ_BIT-1:DATA_LSB+VAL_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields <= '0;
        end else if (bus_wr && hit) begin
            fields.idx <= bus_wdata[IDX_W-1:0];
            fields.val <= bus_wdata[DATA_LSB +: VAL_W];
            fields.req <= bus_wdata[REQ_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[IDX_W-1:0]        = fields.idx;
            bus_rdata[DATA_LSB +: VAL_W] = fields.val;
            bus_rdata[REQ_BIT]           = fields.req;
            bus_rdata[ACK_BIT]           = ack;
        end
    end

    // R3
    other_ofs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != PORT_OFS) |=> $stable(fields));

    // R2
    port_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PORT_OFS) |=> (fields.req == $past(bus_wdata[REQ_BIT])));

endmodule

// File: rtl/phy_dly_hs_fsm.sv
module phy_dly_hs_fsm
    import phy_dly_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ack,
    output logic commit
);

    hs_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:   if (req) state_d = HS_SETTLE;
            HS_SETTLE: state_d = HS_HOLD;
            HS_HOLD:   if (!req) state_d = HS_CLEAR;
            HS_CLEAR:  state_d = HS_IDLE;
        endcase
    end

    always_comb begin
        ack    = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            HS_IDLE:   commit = req;
            HS_SETTLE: ack = 1'b0;
            HS_HOLD:   ack = 1'b1;
            HS_CLEAR:  ack = 1'b1;
        endcase
    end

    // R4
    ack_rise_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req) && !ack) |=> !ack ##1 ack);

    // R5
    ack_fall_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req) && ack) |=> ack ##1 !ack);

    // R6
    held_req_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(req) && ack) |-> !commit);

endmodule

// File: rtl/phy_dly_bank.sv
module phy_dly_bank
    import phy_dly_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [IDX_W-1:0] idx,
    input  logic [VAL_W-1:0] val,
    input  logic [1:0]       mode_sel,
    output logic [VAL_W-1:0] delay_out
);

    logic [VAL_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_reset_val(IDX_W'(i));
        end else if (commit) begin
            slot_q[idx] <= val;
        end
    end

    assign delay_out = slot_q[mode_slot(mode_sel)];

    // R7
    sel_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && idx == mode_slot(mode_sel)) |=> (!$stable(mode_sel) || delay_out == $past(val)));

    // R8
    foreign_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && idx != SLOT_HIGH && idx != SLOT_DEFAULT && idx != SLOT_SDR50 && idx != SLOT_DDR50)
        |=> (!$stable(mode_sel) || $stable(delay_out)));

    // R6
    no_commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (!$stable(mode_sel) || $stable(delay_out)));

endmodule

// File: rtl/phy_dly_port.sv
module phy_dly_port
    import phy_dly_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] PORT_OFS = ADDR_W'(8'h10)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [1:0]        mode_sel,
    output logic [VAL_W-1:0]  delay_out
);

    port_fields_t fields;
    logic         ack;
    logic         commit;

    phy_dly_portreg #(.ADDR_W(ADDR_W), .PORT_OFS(PORT_OFS)) u_portreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ack       (ack),
        .fields    (fields),
        .bus_rdata (bus_rdata)
    );

    phy_dly_hs_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (fields.req),
        .ack    (ack),
        .commit (commit)
    );

    phy_dly_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .idx       (fields.idx),
        .val       (fields.val),
        .mode_sel  (mode_sel),
        .delay_out (delay_out)
    );

    // R9
    ack_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !fields.req) |=> !ack);

endmodule

// File: tb/phy_dly_port_test.sv
`timescale 1ns/100ps
module phy_dly_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h10;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  mode_sel = 2'd0;
    logic [7:0]  delay_out;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] model [256];

    localparam logic [31:0] REQ = 32'h0100_0000;
    localparam logic [31:0] ACK = 32'h0200_0000;

    always #2 clk = ~clk;

    phy_dly_port uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mode_sel(mode_sel), .delay_out(delay_out)
    );

    function automatic int exp_slot(input int m);
        case (m)
            0: return 1;
            1: return 0;
            2: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic logic [31:0] port_word(input logic [7:0] i, input logic [7:0] v, input logic r, input logic a);
        return {6'd0, a, r, 8'd0, v, i};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_modes(input string tag);
        for (int m = 0; m < 4; m++) begin
            mode_sel = 2'(m);
            #0.2;
            check(tag, {24'd0, delay_out}, {24'd0, model[exp_slot(m)]});
        end
    endtask

    task automatic read_port(output logic [31:0] d);
        bus_addr = 8'h10;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h10;
        #0.2;
    endtask

    task automatic handshake(input logic [7:0] i, input logic [7:0] v);
        logic [31:0] rd;
        bus_write(8'h10, port_word(i, v, 1'b0, 1'b0));
        bus_write(8'h10, port_word(i, v, 1'b1, 1'b0));
        read_port(rd);
        check("R4 ack low at edge 0", rd & ACK, 32'd0);
        @(negedge clk); #0.2;
        read_port(rd);
        check("R4 ack low at edge 1", rd & ACK, 32'd0);
        model[i] = v;
        check_modes("R6/R7 commit one edge after request");
        @(negedge clk); #0.2;
        read_port(rd);
        check("R2/R4 readback with ack", rd, port_word(i, v, 1'b1, 1'b1));
        bus_write(8'h10, port_word(i, v, 1'b0, 1'b0));
        read_port(rd);
        check("R5 ack high at edge 0", rd & ACK, ACK);
        @(negedge clk); #0.2;
        read_port(rd);
        check("R5 ack high at edge 1", rd & ACK, ACK);
        @(negedge clk); #0.2;
        read_port(rd);
        check("R5 ack low at edge 2", rd & ACK, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 256; k++) model[k] = 8'h00;
        model[0] = 8'h04; model[1] = 8'h04; model[4] = 8'h06; model[5] = 8'h16;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.2;
        read_port(rd);
        check("R1 port word after reset", rd, 32'd0);
        check_modes("R1 reset delay values");

        // typical programming sequence
        handshake(8'h01, 8'h04);
        handshake(8'h00, 8'h04);
        handshake(8'h04, 8'h06);
        handshake(8'h05, 8'h16);
        handshake(8'h05, 8'hA3);

        // R8 unselected slot
        handshake(8'h22, 8'h5A);
        check_modes("R8 foreign slot leaves output");
        handshake(8'hFF, 8'h11);
        check_modes("R8 top slot leaves output");

        // R3 other offsets
        bus_write(8'h10, port_word(8'h33, 8'h44, 1'b0, 1'b0));
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_addr = 8'h14; #0.2;
        check("R3 read at other offset", bus_rdata, 32'd0);
        read_port(rd);
        check("R3 port unchanged", rd, port_word(8'h33, 8'h44, 1'b0, 1'b0));
        bus_write(8'h00, REQ | 32'h0000_0501);
        @(negedge clk); @(negedge clk); #0.2;
        read_port(rd);
        check("R3 no request from other offset", rd, port_word(8'h33, 8'h44, 1'b0, 1'b0));
        check_modes("R3 no commit from other offset");

        // R9 ack read-only, R2 unused bits
        bus_write(8'h10, ACK | 32'hFC00_0000 | 32'h00FF_0000 | 32'h0000_6655);
        read_port(rd);
        check("R9 ack bit ignored on write", rd, port_word(8'h55, 8'h66, 1'b0, 1'b0));
        @(negedge clk); #0.2;
        read_port(rd);
        check("R9 ack stays low", rd & ACK, 32'd0);

        // R6 held request with changed fields
        bus_write(8'h10, port_word(8'h04, 8'h77, 1'b0, 1'b0));
        bus_write(8'h10, port_word(8'h04, 8'h77, 1'b1, 1'b0));
        model[4] = 8'h77;
        @(negedge clk); @(negedge clk); #0.2;
        bus_write(8'h10, port_word(8'h04, 8'h99, 1'b1, 1'b0));
        bus_write(8'h10, port_word(8'h01, 8'h88, 1'b1, 1'b0));
        repeat (3) @(negedge clk); #0.2;
        check_modes("R6 held request writes nothing more");
        read_port(rd);
        check("R2 held readback", rd, port_word(8'h01, 8'h88, 1'b1, 1'b1));
        bus_write(8'h10, port_word(8'h01, 8'h88, 1'b0, 1'b0));
        @(negedge clk); @(negedge clk); #0.2;
        read_port(rd);
        check("R5 ack low after held release", rd & ACK, 32'd0);
        check_modes("R6 release writes nothing");

        // random mix
        for (int n = 0; n < 150; n++) begin
            logic [7:0] i;
            logic [7:0] v;
            if ($urandom % 2 == 0) i = 8'(exp_slot(int'($urandom % 4)));
            else                   i = 8'($urandom);
            v = 8'($urandom);
            handshake(i, v);
            check_modes("R7 random selection");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule